// File: doc/BRIEF.md
# DMA Channel Lock Controller

This block decides, for each DMA channel, when the channel keeps its hold on the master interface arbitration (channel lock) and when it drives the system bus lock line (bus lock). The channel engine reports start and end events for the whole DMA transfer, for each block, and for each transaction, where a transaction is one single access or one burst. Software sets, for each channel and each lock type, an enable and a scope that picks one of these three event pairs.

A lock takes effect in the same cycle as the start event of its scope. It stays on through the cycle of the matching end event and is off in the cycle after, unless a new start arrives in that cycle. Clearing the channel enable drops both locks at once and discards their state. The channel-lock output sent to the arbiter is the OR of the channel-lock state and the bus-lock state, so the arbitration hold always covers the bus-lock interval. A single system bus lock output is the OR of the bus locks of all channels.

Top module: `dma_lock_ctrl`

## Requirements
- R1: After reset, and with no start events, every channel-lock output, every bus-lock output and the system bus lock are 0.
- R2: Scope code 2'b00 selects the whole-transfer events: the lock is taken on a transfer start and released after a transfer end.
- R3: Scope code 2'b01 selects the block events. Transaction events do not start or end a lock in this scope.
- R4: Scope codes 2'b10 and 2'b11 both select the transaction events. A transaction whose start and end fall in the same cycle holds the lock for exactly that cycle.
- R5: A lock output is 1 in the same cycle as a start event of its scope, provided the channel and that lock type are enabled.
- R6: A held lock stays 1 up to and including the cycle of the end event of its scope. It is 0 in the next cycle unless a new start event occurs in that cycle.
- R7: When the channel enable is 0, both lock outputs of that channel are 0 in that same cycle. The held state is cleared, so the locks stay 0 after the channel is enabled again, until a new start event.
- R8: When a lock type's enable is 0, start events do not take that lock, and setting the enable later does not revive the lock.
- R9: A channel's channel-lock output is 1 whenever that channel's bus-lock output is 1, even when channel locking is disabled.
- R10: The system bus lock output is 1 exactly when at least one channel's bus-lock output is 1.
- R11: Channels are independent. Events and settings of one channel do not change the outputs of another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | NUM_CH | Per-channel enable |
| arb_lk_en | input | NUM_CH | Per-channel enable for the arbitration lock |
| arb_lk_scope | input | 2*NUM_CH | Arbitration lock scope, 2 bits per channel (00 transfer, 01 block, 1x transaction) |
| bus_lk_en | input | NUM_CH | Per-channel enable for the bus lock |
| bus_lk_scope | input | 2*NUM_CH | Bus lock scope, 2 bits per channel, same coding |
| xfer_start | input | NUM_CH | Whole DMA transfer begins |
| xfer_end | input | NUM_CH | Whole DMA transfer finishes |
| blk_start | input | NUM_CH | Block begins |
| blk_end | input | NUM_CH | Block finishes |
| txn_start | input | NUM_CH | Transaction (single access or burst) begins |
| txn_end | input | NUM_CH | Transaction finishes |
| arb_hold | output | NUM_CH | Per-channel request to keep the arbitration grant |
| bus_hold | output | NUM_CH | Per-channel bus lock |
| sys_bus_lock | output | 1 | System bus lock, the OR over channels |

## Verification
A stuck-set held state shows up at the ports in the first cycle after an end event, when the lock output is still 1. A stuck-clear held state shows up one cycle after a start event, when the lock output drops while the scope is still open. A scope decoded to the wrong event pair shows up when another scope's start event takes the lock, or when that scope's own end event fails to release it. A missing clear on disable stays hidden while the channel is off and appears in the first cycle after it is enabled again. Every one of these faults therefore reaches an output no more than one cycle after the event that exposes it.

// File: rtl/dlk_pkg.sv
package dlk_pkg;

  typedef enum logic [1:0] {
    SCOPE_XFER = 2'b00,
    SCOPE_BLK  = 2'b01,
    SCOPE_TXN  = 2'b10,
    SCOPE_RSV  = 2'b11
  } lk_scope_e;

  typedef struct packed {
    logic xfer_start;
    logic xfer_end;
    logic blk_start;
    logic blk_end;
    logic txn_start;
    logic txn_end;
  } lk_ev_t;

  // Start event of the chosen scope; code 11 falls back to transaction.
  function automatic logic scope_start(input logic [1:0] sc, input lk_ev_t ev);
    case (sc)
      SCOPE_XFER: scope_start = ev.xfer_start;
      SCOPE_BLK:  scope_start = ev.blk_start;
      default:    scope_start = ev.txn_start;
    endcase
  endfunction

  function automatic logic scope_end(input logic [1:0] sc, input lk_ev_t ev);
    case (sc)
      SCOPE_XFER: scope_end = ev.xfer_end;
      SCOPE_BLK:  scope_end = ev.blk_end;
      default:    scope_end = ev.txn_end;
    endcase
  endfunction

endpackage

// File: rtl/dlk_tracker.sv
module dlk_tracker
  import dlk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ch_en,
  input  logic       lk_en,
  input  logic [1:0] scope,
  input  lk_ev_t     ev,
  output logic       held
);

  logic start_hit;
  logic end_hit;
  logic armed;
  logic state_q;
  logic state_d;

  assign start_hit = scope_start(scope, ev);
  assign end_hit   = scope_end(scope, ev);
  assign armed     = ch_en & lk_en;
  assign held      = armed & (state_q | start_hit);
  assign state_d   = held & ~end_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 1'b0;
    else        state_q <= state_d;
  end

  // R6: an open lock carries into the next cycle while still armed
  a_r6_hold_open: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !end_hit) |=> (held || !armed));

  // R6: the cycle after an end event is free unless a new start arrives
  a_r6_release_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (held && end_hit) |=> (!held || start_hit));

  // R7: a disabled channel carries no lock into the next cycle
  a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en) |=> (!held || start_hit));

  // R8: a disabled lock type leaves no state behind
  a_r8_off_no_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_en) |=> (!held || start_hit));

endmodule

// File: rtl/dlk_channel.sv
module dlk_channel
  import dlk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ch_en,
  input  logic       arb_en,
  input  logic [1:0] arb_scope,
  input  logic       bus_en,
  input  logic [1:0] bus_scope,
  input  lk_ev_t     ev,
  output logic       arb_hold,
  output logic       bus_hold
);

  logic arb_own;

  dlk_tracker u_arb (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .lk_en(arb_en),
    .scope(arb_scope), .ev(ev), .held(arb_own)
  );

  dlk_tracker u_bus (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .lk_en(bus_en),
    .scope(bus_scope), .ev(ev), .held(bus_hold)
  );

  // The arbitration hold always covers the bus lock interval
  assign arb_hold = arb_own | bus_hold;

endmodule

// File: rtl/dma_lock_ctrl.sv
module dma_lock_ctrl
  import dlk_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   ch_en,
  input  logic [NUM_CH-1:0]   arb_lk_en,
  input  logic [2*NUM_CH-1:0] arb_lk_scope,
  input  logic [NUM_CH-1:0]   bus_lk_en,
  input  logic [2*NUM_CH-1:0] bus_lk_scope,
  input  logic [NUM_CH-1:0]   xfer_start,
  input  logic [NUM_CH-1:0]   xfer_end,
  input  logic [NUM_CH-1:0]   blk_start,
  input  logic [NUM_CH-1:0]   blk_end,
  input  logic [NUM_CH-1:0]   txn_start,
  input  logic [NUM_CH-1:0]   txn_end,
  output logic [NUM_CH-1:0]   arb_hold,
  output logic [NUM_CH-1:0]   bus_hold,
  output logic                sys_bus_lock
);

  localparam int SCW = 2;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    lk_ev_t ev;
    assign ev = '{xfer_start: xfer_start[g], xfer_end: xfer_end[g],
                  blk_start:  blk_start[g],  blk_end:  blk_end[g],
                  txn_start:  txn_start[g],  txn_end:  txn_end[g]};

    dlk_channel u_ch (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en[g]),
      .arb_en(arb_lk_en[g]), .arb_scope(arb_lk_scope[SCW*g +: SCW]),
      .bus_en(bus_lk_en[g]), .bus_scope(bus_lk_scope[SCW*g +: SCW]),
      .ev(ev), .arb_hold(arb_hold[g]), .bus_hold(bus_hold[g])
    );
  end

  assign sys_bus_lock = |bus_hold;

endmodule

// File: tb/dma_lock_ctrl_bench.sv
module dma_lock_ctrl_bench;

  localparam int N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]   ch_en = '0, arb_lk_en = '0, bus_lk_en = '0;
  logic [2*N-1:0] arb_lk_scope = '0, bus_lk_scope = '0;
  logic [N-1:0]   xfer_start = '0, xfer_end = '0, blk_start = '0, blk_end = '0;
  logic [N-1:0]   txn_start = '0, txn_end = '0;
  logic [N-1:0]   arb_hold, bus_hold;
  logic           sys_bus_lock;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  dma_lock_ctrl #(.NUM_CH(N)) u_dma_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en),
    .arb_lk_en(arb_lk_en), .arb_lk_scope(arb_lk_scope),
    .bus_lk_en(bus_lk_en), .bus_lk_scope(bus_lk_scope),
    .xfer_start(xfer_start), .xfer_end(xfer_end),
    .blk_start(blk_start), .blk_end(blk_end),
    .txn_start(txn_start), .txn_end(txn_end),
    .arb_hold(arb_hold), .bus_hold(bus_hold), .sys_bus_lock(sys_bus_lock)
  );

  // Vector: en, arb_en, arb_sc[2], bus_en, bus_sc[2], ev{xs,xe,bs,be,ts,te}, exp_arb, exp_bus
  localparam int NV = 22;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1,1'b1,2'b01,1'b0,2'b00,6'b000000,1'b0,1'b0},  // R3 idle
    {1'b1,1'b1,2'b01,1'b0,2'b00,6'b001000,1'b1,1'b0},  // R3 R5 block start
    {1'b1,1'b1,2'b01,1'b0,2'b00,6'b000011,1'b1,1'b0},  // R3 txn ignored
    {1'b1,1'b1,2'b01,1'b0,2'b00,6'b000000,1'b1,1'b0},  // R6 hold
    {1'b1,1'b1,2'b01,1'b0,2'b00,6'b000100,1'b1,1'b0},  // R6 end cycle
    {1'b1,1'b1,2'b01,1'b0,2'b00,6'b000000,1'b0,1'b0},  // R6 released
    {1'b1,1'b0,2'b00,1'b1,2'b10,6'b000010,1'b1,1'b1},  // R4 R9 txn start
    {1'b1,1'b0,2'b00,1'b1,2'b10,6'b000000,1'b1,1'b1},  // R9 hold
    {1'b1,1'b0,2'b00,1'b1,2'b10,6'b000001,1'b1,1'b1},  // R6 end
    {1'b1,1'b0,2'b00,1'b1,2'b10,6'b000000,1'b0,1'b0},  // R6 released
    {1'b1,1'b0,2'b00,1'b1,2'b11,6'b000011,1'b1,1'b1},  // R4 code 11 one cycle
    {1'b1,1'b0,2'b00,1'b1,2'b11,6'b000000,1'b0,1'b0},  // R4 released
    {1'b1,1'b1,2'b10,1'b1,2'b00,6'b100000,1'b1,1'b1},  // R2 transfer start
    {1'b1,1'b1,2'b10,1'b1,2'b00,6'b000011,1'b1,1'b1},  // R2 txn inside
    {1'b1,1'b1,2'b10,1'b1,2'b00,6'b001100,1'b1,1'b1},  // R2 block inside
    {1'b1,1'b1,2'b10,1'b1,2'b00,6'b010000,1'b1,1'b1},  // R2 transfer end
    {1'b1,1'b1,2'b10,1'b1,2'b00,6'b000000,1'b0,1'b0},  // R2 released
    {1'b1,1'b1,2'b00,1'b1,2'b00,6'b100000,1'b1,1'b1},  // R7 take
    {1'b0,1'b1,2'b00,1'b1,2'b00,6'b000000,1'b0,1'b0},  // R7 disable drops
    {1'b1,1'b1,2'b00,1'b1,2'b00,6'b000000,1'b0,1'b0},  // R7 cleared
    {1'b1,1'b0,2'b00,1'b0,2'b00,6'b100000,1'b0,1'b0},  // R8 start ignored
    {1'b1,1'b1,2'b00,1'b1,2'b00,6'b000000,1'b0,1'b0}   // R8 not revived
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_ev();
    xfer_start = '0; xfer_end = '0; blk_start = '0; blk_end = '0;
    txn_start = '0; txn_end = '0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #3;
    check("R1 arb", {30'd0, arb_hold}, 32'd0);
    check("R1 bus", {30'd0, bus_hold}, 32'd0);
    check("R1 sys", {31'd0, sys_bus_lock}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #3;
    check("R1 after release", {30'd0, arb_hold, bus_hold}, 32'd0);

    // Table walk on channel 0; channel 1 enabled and idle (R11)
    ch_en[1] = 1'b1; arb_lk_en[1] = 1'b1; bus_lk_en[1] = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ch_en[0] = VEC[i][14]; arb_lk_en[0] = VEC[i][13]; arb_lk_scope[1:0] = VEC[i][12:11];
      bus_lk_en[0] = VEC[i][10]; bus_lk_scope[1:0] = VEC[i][9:8];
      xfer_start[0] = VEC[i][7]; xfer_end[0] = VEC[i][6];
      blk_start[0]  = VEC[i][5]; blk_end[0]  = VEC[i][4];
      txn_start[0]  = VEC[i][3]; txn_end[0]  = VEC[i][2];
      #3;
      check($sformatf("R2-table row %0d arb", i), {31'd0, arb_hold[0]}, {31'd0, VEC[i][1]});
      check($sformatf("R5 table row %0d bus", i), {31'd0, bus_hold[0]}, {31'd0, VEC[i][0]});
      check($sformatf("R10 row %0d sys", i), {31'd0, sys_bus_lock}, {31'd0, VEC[i][0]});
      check($sformatf("R11 row %0d ch1", i), {30'd0, arb_hold[1], bus_hold[1]}, 32'd0);
    end

    // R11 R10: channel 1 takes bus lock while channel 0 is idle
    @(negedge clk);
    clear_ev();
    bus_lk_scope[3:2] = 2'b00; arb_lk_scope[3:2] = 2'b01;
    xfer_start[1] = 1'b1;
    #3;
    check("R11 ch1 bus", {31'd0, bus_hold[1]}, 32'd1);
    check("R9 ch1 arb covers bus", {31'd0, arb_hold[1]}, 32'd1);
    check("R11 ch0 untouched", {30'd0, arb_hold[0], bus_hold[0]}, 32'd0);
    check("R10 sys from ch1", {31'd0, sys_bus_lock}, 32'd1);
    @(negedge clk);
    clear_ev();
    blk_end[1] = 1'b1;  // not the bus scope end
    #3;
    check("R2 block end ignored", {31'd0, bus_hold[1]}, 32'd1);
    @(negedge clk);
    clear_ev();
    xfer_end[1] = 1'b1;
    #3;
    check("R6 ch1 end cycle", {31'd0, bus_hold[1]}, 32'd1);
    @(negedge clk);
    clear_ev();
    #3;
    check("R6 ch1 released", {31'd0, bus_hold[1]}, 32'd0);
    check("R10 sys released", {31'd0, sys_bus_lock}, 32'd0);

    // R6: end and new start in back-to-back cycles keep lock
    @(negedge clk);
    txn_start[1] = 1'b1; bus_lk_scope[3:2] = 2'b10;
    #3;
    check("R4 ch1 txn start", {31'd0, bus_hold[1]}, 32'd1);
    @(negedge clk);
    clear_ev(); txn_end[1] = 1'b1;
    #3;
    check("R6 ch1 txn end", {31'd0, bus_hold[1]}, 32'd1);
    @(negedge clk);
    clear_ev(); txn_start[1] = 1'b1;
    #3;
    check("R6 restart after end", {31'd0, bus_hold[1]}, 32'd1);
    @(negedge clk);
    clear_ev();
    #3;
    check("R6 restart holds", {31'd0, bus_hold[1]}, 32'd1);
    @(negedge clk);
    ch_en[1] = 1'b0;
    #3;
    check("R7 ch1 disable", {30'd0, arb_hold[1], bus_hold[1]}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule